// File: doc/BRIEF.md
# Tester Pin Channel Vector Engine

This block drives and checks one pin of a device under test during a functional pattern run. A small on-chip store holds one pin state per vector, along with a 2-bit index into a four-entry timing table. Each table entry gives two tick positions inside the vector period: the tick at which the driver takes its new level, and the tick at which the comparator pair is sampled. The vector period is a fixed number of fast clock ticks, so every vector lasts `PERIOD` cycles of `clk`.

A `start` pulse steps through the vectors from address 0 up to the last address that was latched with the pulse. For drive vectors the block produces a driver enable and a logic level. Expect vectors turn the driver off and are judged against two digital comparator outputs at the strobe tick. Masked vectors neither drive nor compare. Failures are counted in a saturating counter, and the address of the first failing vector is kept. When the last vector ends, `done` rises, and `pass` is true only if no failure was seen.

Top module: `pin_vec_engine`

## Requirements
- R1: After reset, drv_en, drv_level, busy, done, pass, fail_count and first_fail_valid are all 0.
- R2: State code 0 (drive low) and code 1 (drive high) switch the driver on from the vector's drive-edge tick to the end of the vector, with drv_level 0 for code 0 and 1 for code 1.
- R3: During vectors with code 2 (expect low), code 3 (expect high) or code 4 to 7 (masked), and whenever no run is active, drv_en is 0. drv_level is 0 whenever drv_en is 0.
- R4: In a drive vector, the ticks before the drive edge keep the driver state of the previous vector. If the previous vector was not a drive vector (or this is the first vector of the run), the driver stays off until the edge. If the previous vector was a drive vector, the driver stays on at the previous level until the edge.
- R5: Bits [1:0] of each vector select one of four timing entries. Each entry holds a drive-edge tick and a strobe tick, both in the range 0 to PERIOD-1 counted from the start of the vector.
- R6: The comparator pair is sampled only at the strobe tick. An expect-high vector fails unless cmp_hi is 1, and an expect-low vector fails unless cmp_lo is 1. A reading with both comparators at 0 therefore fails either expectation.
- R7: Masked vectors (codes 4 to 7) and drive vectors never record a failure, whatever the comparators read.
- R8: The first failing vector's address appears on first_fail_addr, with first_fail_valid set. Later failures do not change it until the next run starts.
- R9: fail_count counts failing vectors and holds at its all-ones maximum once it is reached.
- R10: An accepted start pulse clears the failure record, latches last_addr and runs vectors 0 through last_addr, for (last_addr+1)*PERIOD cycles. busy drops and done rises at the same edge, and pass equals done with fail_count at 0.
- R11: A start pulse during a run is ignored. The run keeps its address, timing and failure record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| vec_we | input | 1 | Write strobe for the vector store |
| vec_waddr | input | ADDR_W | Vector store write address |
| vec_wstate | input | 3 | Pin state code to store |
| vec_wts | input | 2 | Timing entry index to store |
| ts_we | input | 1 | Write strobe for the timing table |
| ts_waddr | input | 2 | Timing table entry to write |
| ts_wdrive | input | TICK_W | Drive-edge tick for the entry |
| ts_wstrobe | input | TICK_W | Strobe tick for the entry |
| start | input | 1 | Run request pulse |
| last_addr | input | ADDR_W | Last vector address of the run, latched at start |
| cmp_hi | input | 1 | Comparator: pin above the high threshold |
| cmp_lo | input | 1 | Comparator: pin below the low threshold |
| drv_en | output | 1 | Driver enable toward the pin |
| drv_level | output | 1 | Driven logic level |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| pass | output | 1 | Run finished with zero failures |
| fail_count | output | CNT_W | Saturating count of failing vectors |
| first_fail_valid | output | 1 | A failure has been recorded this run |
| first_fail_addr | output | ADDR_W | Address of the first failing vector |

## Verification
The bench targets the switch from an expect vector into a drive vector with a late edge. A design that enabled the driver at the start of the vector would fight the device for several ticks, and the bench catches this with a check on every tick. It also covers a drive vector that follows another drive vector, where dropping the enable or jumping early to the new level would show up before the edge. Comparator readings with both outputs at 0 must fail both expectations, and a masked vector with a wrong reading must not count. A design that compared only one comparator, or that ignored the mask, would report the wrong count. Further runs push the counter past its maximum (a wrapping counter would read low) and send a start pulse in the middle of a run (a restart would clear the record and finish late). They also use short last addresses, where an off-by-one would shift done by a whole vector period.

// File: rtl/pve_pkg.sv
package pve_pkg;

    localparam int STATE_W = 3;
    localparam int TS_IDX_W = 2;
    localparam int TS_ENTRIES = 1 << TS_IDX_W;

    typedef enum logic [STATE_W-1:0] {
        PS_DRIVE_LO = 3'd0,
        PS_DRIVE_HI = 3'd1,
        PS_EXPECT_LO = 3'd2,
        PS_EXPECT_HI = 3'd3,
        PS_MASKED = 3'd4
    } pin_state_e;

    typedef struct packed {
        logic [STATE_W-1:0] code;
        logic [TS_IDX_W-1:0] ts_sel;
    } vec_word_t;

    function automatic logic is_drive(input logic [STATE_W-1:0] code);
        return (code == PS_DRIVE_LO) || (code == PS_DRIVE_HI);
    endfunction

    function automatic logic drive_bit(input logic [STATE_W-1:0] code);
        return code == PS_DRIVE_HI;
    endfunction

    function automatic logic strobe_miss(input logic [STATE_W-1:0] code,
                                         input logic hi, input logic lo);
        return ((code == PS_EXPECT_HI) && !hi) || ((code == PS_EXPECT_LO) && !lo);
    endfunction

endpackage

// File: rtl/pve_store.sv
module pve_store
    import pve_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int TICK_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vec_we,
    input  logic [ADDR_W-1:0]   vec_waddr,
    input  logic [STATE_W-1:0]  vec_wstate,
    input  logic [TS_IDX_W-1:0] vec_wts,
    input  logic                ts_we,
    input  logic [TS_IDX_W-1:0] ts_waddr,
    input  logic [TICK_W-1:0]   ts_wdrive,
    input  logic [TICK_W-1:0]   ts_wstrobe,
    input  logic [ADDR_W-1:0]   rd_addr,
    output vec_word_t           rd_vec,
    output logic [TICK_W-1:0]   rd_edge,
    output logic [TICK_W-1:0]   rd_strobe
);
    localparam int DEPTH = 1 << ADDR_W;

    vec_word_t         mem [DEPTH];
    logic [TICK_W-1:0] edge_tab [TS_ENTRIES];
    logic [TICK_W-1:0] strobe_tab [TS_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '{code: PS_MASKED, ts_sel: '0};
            end
        end else if (vec_we) begin
            mem[vec_waddr] <= '{code: vec_wstate, ts_sel: vec_wts};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TS_ENTRIES; j++) begin
                edge_tab[j] <= '0;
                strobe_tab[j] <= '0;
            end
        end else if (ts_we) begin
            edge_tab[ts_waddr] <= ts_wdrive;
            strobe_tab[ts_waddr] <= ts_wstrobe;
        end
    end

    always_comb begin
        rd_vec = mem[rd_addr];
        rd_edge = edge_tab[rd_vec.ts_sel];
        rd_strobe = strobe_tab[rd_vec.ts_sel];
    end

endmodule

// File: rtl/pve_seq.sv
module pve_seq #(
    parameter int ADDR_W = 4,
    parameter int PERIOD = 8,
    parameter int TICK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic [TICK_W-1:0] tick,
    output logic              run_start,
    output logic              vec_end
);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PERIOD - 1);

    logic [ADDR_W-1:0] run_last;

    assign run_start = start && !busy;
    assign vec_end = busy && (tick == LAST_TICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            addr <= '0;
            tick <= '0;
            run_last <= '0;
        end else if (run_start) begin
            busy <= 1'b1;
            done <= 1'b0;
            addr <= '0;
            tick <= '0;
            run_last <= last_addr;
        end else if (busy) begin
            if (tick == LAST_TICK) begin
                tick <= '0;
                if (addr == run_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    addr <= addr + 1'b1;
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pve_fmt.sv
module pve_fmt
    import pve_pkg::*;
#(
    parameter int TICK_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  logic               run_start,
    input  logic               vec_end,
    input  logic [STATE_W-1:0] code,
    input  logic [TICK_W-1:0]  tick,
    input  logic [TICK_W-1:0]  drive_edge,
    output logic               drv_en,
    output logic               drv_level
);
    logic prev_en;
    logic prev_lvl;
    logic past_edge;

    always_comb begin
        past_edge = tick >= drive_edge;
        drv_en = busy && is_drive(code) && (past_edge || prev_en);
        drv_level = drv_en && (past_edge ? drive_bit(code) : prev_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst || run_start) begin
            prev_en <= 1'b0;
            prev_lvl <= 1'b0;
        end else if (vec_end) begin
            prev_en <= drv_en;
            prev_lvl <= drv_level;
        end
    end

endmodule

// File: rtl/pve_cmp.sv
module pve_cmp
    import pve_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W = 3,
    parameter int TICK_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_start,
    input  logic               busy,
    input  logic [TICK_W-1:0]  tick,
    input  logic [TICK_W-1:0]  strobe_tick,
    input  logic [STATE_W-1:0] code,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               cmp_hi,
    input  logic               cmp_lo,
    output logic [CNT_W-1:0]   fail_count,
    output logic               first_valid,
    output logic [ADDR_W-1:0]  first_addr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hit;

    assign hit = busy && (tick == strobe_tick) && strobe_miss(code, cmp_hi, cmp_lo);

    always_ff @(posedge clk) begin
        if (rst || run_start) begin
            fail_count <= '0;
            first_valid <= 1'b0;
            first_addr <= '0;
        end else if (hit) begin
            if (fail_count != CNT_MAX) begin
                fail_count <= fail_count + 1'b1;
            end
            if (!first_valid) begin
                first_valid <= 1'b1;
                first_addr <= addr;
            end
        end
    end

endmodule

// File: rtl/pin_vec_engine.sv
module pin_vec_engine
    import pve_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PERIOD = 8,
    parameter int CNT_W = 3,
    localparam int TICK_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vec_we,
    input  logic [ADDR_W-1:0]   vec_waddr,
    input  logic [2:0]          vec_wstate,
    input  logic [1:0]          vec_wts,
    input  logic                ts_we,
    input  logic [1:0]          ts_waddr,
    input  logic [TICK_W-1:0]   ts_wdrive,
    input  logic [TICK_W-1:0]   ts_wstrobe,
    input  logic                start,
    input  logic [ADDR_W-1:0]   last_addr,
    input  logic                cmp_hi,
    input  logic                cmp_lo,
    output logic                drv_en,
    output logic                drv_level,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic [CNT_W-1:0]    fail_count,
    output logic                first_fail_valid,
    output logic [ADDR_W-1:0]   first_fail_addr
);
    logic [ADDR_W-1:0] addr;
    logic [TICK_W-1:0] tick;
    logic              run_start;
    logic              vec_end;
    vec_word_t         cur_vec;
    logic [TICK_W-1:0] cur_edge;
    logic [TICK_W-1:0] cur_strobe;
    logic              at_drive_edge;

    pve_seq #(.ADDR_W(ADDR_W), .PERIOD(PERIOD), .TICK_W(TICK_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .last_addr(last_addr),
        .busy(busy), .done(done), .addr(addr), .tick(tick),
        .run_start(run_start), .vec_end(vec_end)
    );

    pve_store #(.ADDR_W(ADDR_W), .TICK_W(TICK_W)) u_store (
        .clk(clk), .rst(rst),
        .vec_we(vec_we), .vec_waddr(vec_waddr), .vec_wstate(vec_wstate), .vec_wts(vec_wts),
        .ts_we(ts_we), .ts_waddr(ts_waddr), .ts_wdrive(ts_wdrive), .ts_wstrobe(ts_wstrobe),
        .rd_addr(addr), .rd_vec(cur_vec), .rd_edge(cur_edge), .rd_strobe(cur_strobe)
    );

    pve_fmt #(.TICK_W(TICK_W)) u_fmt (
        .clk(clk), .rst(rst), .busy(busy), .run_start(run_start), .vec_end(vec_end),
        .code(cur_vec.code), .tick(tick), .drive_edge(cur_edge),
        .drv_en(drv_en), .drv_level(drv_level)
    );

    pve_cmp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TICK_W(TICK_W)) u_cmp (
        .clk(clk), .rst(rst), .run_start(run_start), .busy(busy),
        .tick(tick), .strobe_tick(cur_strobe), .code(cur_vec.code), .addr(addr),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .fail_count(fail_count), .first_valid(first_fail_valid), .first_addr(first_fail_addr)
    );

    assign at_drive_edge = busy && is_drive(cur_vec.code) && (tick == cur_edge);
    assign pass = done && (fail_count == '0);

endmodule

// File: rtl/pve_chk.sv
module pve_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             pass,
    input logic             drv_en,
    input logic             drv_level,
    input logic             at_drive_edge,
    input logic [CNT_W-1:0] fail_count,
    input logic             first_fail_valid
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r3_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !drv_en);

    a_r3_level_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> !drv_level);

    a_r4_enable_rises_at_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> at_drive_edge);

    a_r9_count_holds_at_max: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(fail_count) == CMAX) |-> fail_count == CMAX);

    a_r8_first_tracks_count: assert property (@(posedge clk) disable iff (rst)
        first_fail_valid == (fail_count != '0));

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
        pass |-> (done && fail_count == '0));

endmodule

bind pin_vec_engine pve_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .pass(pass),
    .drv_en(drv_en), .drv_level(drv_level), .at_drive_edge(at_drive_edge),
    .fail_count(fail_count), .first_fail_valid(first_fail_valid)
);

// File: tb/pin_vec_engine_tb.sv
module pin_vec_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int PERIOD = 8;
    localparam int CNT_W = 3;
    localparam int TICK_W = 3;
    localparam int NPROG = 10;

    // each entry: {state[2:0], timeset[1:0], cmp_hi, cmp_lo}
    localparam logic [6:0] PROG [NPROG] = '{
        7'b001_00_00, 7'b000_01_00, 7'b011_00_10, 7'b001_10_00, 7'b010_01_01,
        7'b011_10_00, 7'b010_11_00, 7'b100_00_01, 7'b010_00_10, 7'b000_00_11
    };

    logic clk = 0;
    logic rst = 1;
    logic vec_we = 0;
    logic [ADDR_W-1:0] vec_waddr = '0;
    logic [2:0] vec_wstate = '0;
    logic [1:0] vec_wts = '0;
    logic ts_we = 0;
    logic [1:0] ts_waddr = '0;
    logic [TICK_W-1:0] ts_wdrive = '0;
    logic [TICK_W-1:0] ts_wstrobe = '0;
    logic start = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic cmp_hi = 0;
    logic cmp_lo = 0;
    logic drv_en, drv_level, busy, done, pass, first_fail_valid;
    logic [CNT_W-1:0] fail_count;
    logic [ADDR_W-1:0] first_fail_addr;

    int total = 0;
    int bad = 0;

    logic [2:0] m_state [16];
    logic [1:0] m_ts [16];
    logic m_hi [16];
    logic m_lo [16];
    int m_edge [4];
    int m_strobe [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_vec_engine #(.ADDR_W(ADDR_W), .PERIOD(PERIOD), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .vec_we(vec_we), .vec_waddr(vec_waddr),
        .vec_wstate(vec_wstate), .vec_wts(vec_wts), .ts_we(ts_we), .ts_waddr(ts_waddr),
        .ts_wdrive(ts_wdrive), .ts_wstrobe(ts_wstrobe), .start(start), .last_addr(last_addr),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .drv_en(drv_en), .drv_level(drv_level),
        .busy(busy), .done(done), .pass(pass), .fail_count(fail_count),
        .first_fail_valid(first_fail_valid), .first_fail_addr(first_fail_addr)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic put_vec(input int a, input logic [2:0] st, input logic [1:0] ts,
                           input logic hi, input logic lo);
        @(negedge clk);
        vec_we = 1; vec_waddr = ADDR_W'(a); vec_wstate = st; vec_wts = ts;
        m_state[a] = st; m_ts[a] = ts; m_hi[a] = hi; m_lo[a] = lo;
        @(negedge clk);
        vec_we = 0;
    endtask

    task automatic put_ts(input int i, input int d, input int s);
        @(negedge clk);
        ts_we = 1; ts_waddr = 2'(i); ts_wdrive = TICK_W'(d); ts_wstrobe = TICK_W'(s);
        m_edge[i] = d; m_strobe[i] = s;
        @(negedge clk);
        ts_we = 0;
    endtask

    // runs vectors 0..last, checks the driver each tick and the result at the end
    task automatic run(input int last, input int glitch_v, input int glitch_t);
        int fails = 0;
        int first = -1;
        logic p_en = 0;
        logic p_lvl = 0;
        @(negedge clk);
        last_addr = ADDR_W'(last);
        start = 1;
        @(negedge clk);
        start = 0;
        for (int v = 0; v <= last; v++) begin
            for (int t = 0; t < PERIOD; t++) begin
                logic e_en, e_lvl, drv;
                int ed;
                cmp_hi = m_hi[v];
                cmp_lo = m_lo[v];
                start = (v == glitch_v && t == glitch_t);
                if (v == glitch_v && t == glitch_t) last_addr = '0;
                ed = m_edge[m_ts[v]];
                drv = (m_state[v] == 3'd0) || (m_state[v] == 3'd1);
                e_en = drv && (t >= ed || p_en);
                e_lvl = e_en && ((t >= ed) ? m_state[v][0] : p_lvl);
                #1;
                // R2 R3 R4 R5: driver enable and level per tick
                chk(drv_en === e_en, "R2_R3_R4", "drv_en", int'(drv_en), int'(e_en));
                chk(drv_level === e_lvl, "R2_R3_R4", "drv_level", int'(drv_level), int'(e_lvl));
                if (t == m_strobe[m_ts[v]] &&
                    ((m_state[v] == 3'd3 && !m_hi[v]) || (m_state[v] == 3'd2 && !m_lo[v]))) begin
                    fails++;
                    if (first < 0) first = v;
                end
                if (t == PERIOD - 1) begin
                    p_en = e_en; p_lvl = e_lvl;
                    // R10: still running on the last tick of the run
                    if (v == last) chk(busy === 1'b1 && done === 1'b0, "R10", "busy before end",
                                       int'(busy), 1);
                end
                @(negedge clk);
            end
        end
        start = 0;
        #1;
        chk(done === 1'b1 && busy === 1'b0, "R10", "done at end", int'(done), 1);
        chk(drv_en === 1'b0, "R3", "idle drv_en", int'(drv_en), 0);
        chk(pass === (fails == 0), "R10", "pass", int'(pass), int'(fails == 0));
        chk(int'(fail_count) == ((fails > 7) ? 7 : fails), "R6_R7_R9", "fail_count",
            int'(fail_count), (fails > 7) ? 7 : fails);
        chk(first_fail_valid === (first >= 0), "R8", "first_fail_valid",
            int'(first_fail_valid), int'(first >= 0));
        if (first >= 0)
            chk(int'(first_fail_addr) == first, "R8", "first_fail_addr",
                int'(first_fail_addr), first);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(drv_en === 0 && drv_level === 0, "R1", "driver after reset", int'(drv_en), 0);
        chk(busy === 0 && done === 0 && pass === 0, "R1", "flags after reset", int'(busy | done | pass), 0);
        chk(fail_count === '0 && first_fail_valid === 0, "R1", "fail record after reset",
            int'(fail_count), 0);
        @(negedge clk);
        rst = 0;

        // R5: timing entries, edge/strobe ticks
        put_ts(0, 0, 4);
        put_ts(1, 3, 6);
        put_ts(2, 5, 7);
        put_ts(3, 2, 0);
        for (int i = 0; i < NPROG; i++)
            put_vec(i, PROG[i][6:4], PROG[i][3:2], PROG[i][1], PROG[i][0]);

        // main table run: mixed drive, expect, mid-level and masked vectors (R6 R7)
        run(NPROG - 1, -1, -1);
        // shorter run, all passing (R10)
        run(4, -1, -1);
        // single-vector run (R10)
        run(0, -1, -1);

        // saturation and restart-ignored: 16 failing expect-high vectors (R9 R11)
        for (int i = 0; i < 16; i++) put_vec(i, 3'd3, 2'd3, 1'b0, 1'b1);
        run(15, 3, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule